// File: doc/BRIEF.md
# Output Delay Window Scan and Centring Calibrator

This block tunes the output delay tap of each byte lane of a memory data path. For each byte in turn it moves the lane's delay tap from 0 to the top tap, one step at a time, through a request and acknowledge exchange with the delay control. After every step it waits a fixed settle time and then takes one pass/fail result for capture on the rising clock edge and one for capture on the falling edge. From how those two results change along the sweep it records where each of the two valid windows opens and closes.

When the sweep reaches the top tap, the block turns the recorded edges into a lower and an upper tap limit and signals that the limits are ready. One cycle later it signals that centring has begun. It then steps the tap down to the midpoint of the limits, stores that tap in the packed result for the byte and signals that centring is done. After the last byte it raises a done level. A sticky flag reports any byte in which no window edge was found.

Top module: `dwin_tap_cal`

## Requirements
- R1: While in reset and after it, before any start, cal_done, tap_req, limits_done, center_start, center_done and win_not_found are low, byte_idx is 0 and final_taps is all zeros.
- R2: For each byte the sweep starts at tap 0 and takes exactly TAP_MAX (63) increment steps. Each step is a tap_req with tap_dir_up high, and tap_req and tap_dir_up hold steady until tap_ack is seen.
- R3: A left edge is the first tap t > 0 at which the sample is stable while the sample at t-1 was unstable. The tap value t is recorded and its valid bit is set. No left edge is recorded after a right edge has been found, and a stable sample at tap 0 records no edge.
- R4: A right edge is the last stable tap before the first change from stable to unstable. If the sample is still stable at tap 63, no right edge is recorded.
- R5: The rise and fall windows are tracked separately. edge_valid bit 0 is rise-left, bit 1 is rise-right, bit 2 is fall-left and bit 3 is fall-right. edge_taps holds the four 6-bit taps in that same order, the rise-left tap in bits [5:0]. A left tap is never larger than the right tap of the same window.
- R6: The bounds of a window are its left tap (or 0 if no left edge) and its right tap (or 63 if no right edge). A window counts only if at least one of its edges is valid. If both windows count and overlap, the limits are the overlap. If they do not overlap, the rise window is used. If only one window counts, that window is used.
- R7: limits_done is a one-cycle pulse, and lim_lo, lim_hi and edge_taps are valid while it is high. center_start pulses exactly in the next cycle, and at most one of limits_done, center_start and center_done is high at a time.
- R8: Centring moves the tap down from 63 to floor((lim_lo + lim_hi) / 2) with decrement steps (tap_dir_up low), 63 minus the target in all. center_done then pulses once, and the tap is written to final_taps bits [6*b+5 : 6*b] for byte b.
- R9: Bytes are calibrated in order 0, 1, and so on, one at a time. byte_idx shows the current byte and never exceeds NUM_BYTES-1.
- R10: If a byte has no valid edge in either window, win_not_found is set, the limits are 0 and 63, and the final tap for that byte is 0. The flag stays set until the next start.
- R11: cal_start in the idle state clears cal_done and final_taps. cal_done goes high after the last byte's center_done and stays high until the next start.
- R12: A result is taken only after SETTLE cycles have passed since the accepted tap change, and only while smp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Starts a calibration run when idle |
| cal_done | output | 1 | Run complete; held until next start |
| byte_idx | output | BYTE_W | Byte currently being calibrated |
| tap_req | output | 1 | Tap step request |
| tap_dir_up | output | 1 | 1 = increment, 0 = decrement |
| tap_ack | input | 1 | Delay control accepted the step |
| smp_valid | input | 1 | Sample results are valid |
| smp_rise_ok | input | 1 | Rising-edge capture result is stable |
| smp_fall_ok | input | 1 | Falling-edge capture result is stable |
| edge_taps | output | 4*TAP_W | Edge taps of the current byte |
| edge_valid | output | 4 | Validity of each edge |
| lim_lo | output | TAP_W | Lower tap limit |
| lim_hi | output | TAP_W | Upper tap limit |
| limits_done | output | 1 | Limits ready pulse |
| center_start | output | 1 | Centring begins pulse |
| center_done | output | 1 | Centring finished pulse |
| win_not_found | output | 1 | Sticky no-edge flag |
| final_taps | output | NUM_BYTES*TAP_W | Packed final taps per byte |

## Verification
Every output comes from a register, so a result becomes visible one clock after the decision that causes it. The bench therefore drives inputs and reads outputs on the falling edge, half a cycle after any change. A tap step is accepted on the rising edge after the bench raises tap_ack. The result for that tap is taken SETTLE+1 rising edges later, so the bench returns inverted results during the first SETTLE cycles after each step, and a sample taken too early shows up as a wrong edge. The bench takes the edge taps and limits in the falling-edge slot where limits_done is high, and it requires center_start in the very next slot. It checks the final taps and the step counts once cal_done rises.

// File: rtl/dwin_pkg.sv
`timescale 1ns/1ps
package dwin_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SETTLE, S_WAIT, S_STEP, S_LIMIT,
    S_LDONE, S_CSTART, S_CENTER, S_CDONE
  } cal_st_e;
endpackage

// File: rtl/dwin_edge_track.sv
`timescale 1ns/1ps
// Tracks the left and right edge of one capture window along a tap sweep.
module dwin_edge_track #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             first,
  input  logic             cur,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] left_tap,
  output logic [TAP_W-1:0] right_tap,
  output logic             left_ok,
  output logic             right_ok
);
  logic             prev_q, prev_d;
  logic [TAP_W-1:0] l_q, l_d, r_q, r_d;
  logic             lv_q, lv_d, rv_q, rv_d;

  always_comb begin
    prev_d = prev_q;
    l_d = l_q; r_d = r_q; lv_d = lv_q; rv_d = rv_q;
    if (clr) begin
      prev_d = 1'b0; l_d = '0; r_d = '0; lv_d = 1'b0; rv_d = 1'b0;
    end else if (take) begin
      prev_d = cur;
      if (!first) begin
        // unstable -> stable: opening edge, only before any closing edge
        if (!prev_q && cur && !lv_q && !rv_q) begin
          l_d = tap; lv_d = 1'b1;
        end
        // stable -> unstable: last stable tap closes the window
        if (prev_q && !cur && !rv_q) begin
          r_d = tap - TAP_W'(1); rv_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0; l_q <= '0; r_q <= '0; lv_q <= 1'b0; rv_q <= 1'b0;
    end else begin
      prev_q <= prev_d; l_q <= l_d; r_q <= r_d; lv_q <= lv_d; rv_q <= rv_d;
    end
  end

  assign left_tap  = l_q;
  assign right_tap = r_q;
  assign left_ok   = lv_q;
  assign right_ok  = rv_q;

  p_edge_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_q && rv_q) |-> (l_q <= r_q));
  p_left_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_q && !clr) |=> (lv_q && $stable(l_q)));
  p_right_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !clr) |=> (rv_q && $stable(r_q)));
endmodule

// File: rtl/dwin_limits.sv
`timescale 1ns/1ps
// Turns the four edges into tap limits and a centre tap.
module dwin_limits #(
  parameter int TAP_W = 6
) (
  input  logic [TAP_W-1:0] rise_l,
  input  logic [TAP_W-1:0] rise_r,
  input  logic [TAP_W-1:0] fall_l,
  input  logic [TAP_W-1:0] fall_r,
  input  logic             rise_lv,
  input  logic             rise_rv,
  input  logic             fall_lv,
  input  logic             fall_rv,
  output logic [TAP_W-1:0] lo,
  output logic [TAP_W-1:0] hi,
  output logic [TAP_W-1:0] mid,
  output logic             none
);
  localparam logic [TAP_W-1:0] TOP = '1;
  logic [TAP_W-1:0] rlo, rhi, flo, fhi, olo, ohi;
  logic             rhas, fhas;
  logic [TAP_W:0]   sum;

  always_comb begin
    rlo  = rise_lv ? rise_l : '0;
    rhi  = rise_rv ? rise_r : TOP;
    flo  = fall_lv ? fall_l : '0;
    fhi  = fall_rv ? fall_r : TOP;
    rhas = rise_lv | rise_rv;
    fhas = fall_lv | fall_rv;
    olo  = (rlo > flo) ? rlo : flo;
    ohi  = (rhi < fhi) ? rhi : fhi;
    none = 1'b0;
    if (rhas && fhas && (olo <= ohi)) begin
      lo = olo; hi = ohi;
    end else if (rhas) begin
      lo = rlo; hi = rhi;
    end else if (fhas) begin
      lo = flo; hi = fhi;
    end else begin
      lo = '0; hi = TOP; none = 1'b1;
    end
    sum = {1'b0, lo} + {1'b0, hi};
    mid = none ? '0 : sum[TAP_W:1];
  end
endmodule

// File: rtl/dwin_tap_cal.sv
`timescale 1ns/1ps
module dwin_tap_cal
  import dwin_pkg::*;
#(
  parameter int NUM_BYTES = 2,
  parameter int TAP_W     = 6,
  parameter int SETTLE    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cal_start,
  output logic                       cal_done,
  output logic [((NUM_BYTES>1)?$clog2(NUM_BYTES):1)-1:0] byte_idx,
  output logic                       tap_req,
  output logic                       tap_dir_up,
  input  logic                       tap_ack,
  input  logic                       smp_valid,
  input  logic                       smp_rise_ok,
  input  logic                       smp_fall_ok,
  output logic [4*TAP_W-1:0]         edge_taps,
  output logic [3:0]                 edge_valid,
  output logic [TAP_W-1:0]           lim_lo,
  output logic [TAP_W-1:0]           lim_hi,
  output logic                       limits_done,
  output logic                       center_start,
  output logic                       center_done,
  output logic                       win_not_found,
  output logic [NUM_BYTES*TAP_W-1:0] final_taps
);
  localparam int BYTE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int CNT_W  = $clog2(SETTLE + 1);
  localparam logic [TAP_W-1:0]  TAP_TOP   = '1;
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(NUM_BYTES - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  cal_st_e st_q, st_d;
  logic [TAP_W-1:0]           tap_q, tap_d, tgt_q, tgt_d, lo_q, lo_d, hi_q, hi_d;
  logic [BYTE_W-1:0]          byte_q, byte_d;
  logic [CNT_W-1:0]           scnt_q, scnt_d;
  logic [NUM_BYTES*TAP_W-1:0] fin_q, fin_d;
  logic                       nf_q, nf_d, done_q, done_d;

  logic             take, byte_clr;
  logic [1:0]       cur_ok, l_ok, r_ok;
  logic [TAP_W-1:0] l_tap [2];
  logic [TAP_W-1:0] r_tap [2];
  logic [TAP_W-1:0] calc_lo, calc_hi, calc_mid;
  logic             calc_none;

  assign cur_ok   = {smp_fall_ok, smp_rise_ok};
  assign take     = (st_q == S_WAIT) && smp_valid;
  assign byte_clr = ((st_q == S_IDLE) && cal_start) ||
                    ((st_q == S_CDONE) && (byte_q != LAST_BYTE));

  // index 0 = rising-edge window, index 1 = falling-edge window
  for (genvar g = 0; g < 2; g++) begin : g_win
    dwin_edge_track #(.TAP_W(TAP_W)) u_trk (
      .clk(clk), .rst_n(arst_n), .clr(byte_clr), .take(take),
      .first(tap_q == '0), .cur(cur_ok[g]), .tap(tap_q),
      .left_tap(l_tap[g]), .right_tap(r_tap[g]),
      .left_ok(l_ok[g]), .right_ok(r_ok[g])
    );
  end

  dwin_limits #(.TAP_W(TAP_W)) u_lim (
    .rise_l(l_tap[0]), .rise_r(r_tap[0]), .fall_l(l_tap[1]), .fall_r(r_tap[1]),
    .rise_lv(l_ok[0]), .rise_rv(r_ok[0]), .fall_lv(l_ok[1]), .fall_rv(r_ok[1]),
    .lo(calc_lo), .hi(calc_hi), .mid(calc_mid), .none(calc_none)
  );

  always_comb begin
    st_d = st_q; tap_d = tap_q; tgt_d = tgt_q; lo_d = lo_q; hi_d = hi_q;
    byte_d = byte_q; scnt_d = scnt_q; fin_d = fin_q; nf_d = nf_q; done_d = done_q;
    case (st_q)
      S_IDLE: if (cal_start) begin
        st_d = S_SETTLE; tap_d = '0; byte_d = '0; scnt_d = '0;
        fin_d = '0; nf_d = 1'b0; done_d = 1'b0;
      end
      S_SETTLE: if (scnt_q == CNT_W'(SETTLE - 1)) begin
        scnt_d = '0; st_d = S_WAIT;
      end else begin
        scnt_d = scnt_q + CNT_W'(1);
      end
      S_WAIT: if (smp_valid) st_d = (tap_q == TAP_TOP) ? S_LIMIT : S_STEP;
      S_STEP: if (tap_ack) begin
        tap_d = tap_q + TAP_W'(1); st_d = S_SETTLE;
      end
      S_LIMIT: begin
        lo_d = calc_lo; hi_d = calc_hi; tgt_d = calc_mid;
        nf_d = nf_q | calc_none; st_d = S_LDONE;
      end
      S_LDONE:  st_d = S_CSTART;
      S_CSTART: st_d = S_CENTER;
      S_CENTER: if (tap_q == tgt_q) begin
        st_d = S_CDONE;
        fin_d[byte_q*TAP_W +: TAP_W] = tap_q;
      end else if (tap_ack) begin
        tap_d = tap_q - TAP_W'(1);
      end
      S_CDONE: if (byte_q == LAST_BYTE) begin
        st_d = S_IDLE; done_d = 1'b1;
      end else begin
        byte_d = byte_q + BYTE_W'(1); tap_d = '0; scnt_d = '0; st_d = S_SETTLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q <= S_IDLE; tap_q <= '0; tgt_q <= '0; lo_q <= '0; hi_q <= '0;
      byte_q <= '0; scnt_q <= '0; fin_q <= '0; nf_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; tap_q <= tap_d; tgt_q <= tgt_d; lo_q <= lo_d; hi_q <= hi_d;
      byte_q <= byte_d; scnt_q <= scnt_d; fin_q <= fin_d; nf_q <= nf_d; done_q <= done_d;
    end
  end

  assign tap_req       = (st_q == S_STEP) || ((st_q == S_CENTER) && (tap_q != tgt_q));
  assign tap_dir_up    = (st_q == S_STEP);
  assign limits_done   = (st_q == S_LDONE);
  assign center_start  = (st_q == S_CSTART);
  assign center_done   = (st_q == S_CDONE);
  assign cal_done      = done_q;
  assign win_not_found = nf_q;
  assign byte_idx      = byte_q;
  assign lim_lo        = lo_q;
  assign lim_hi        = hi_q;
  assign final_taps    = fin_q;
  assign edge_taps     = {r_tap[1], l_tap[1], r_tap[0], l_tap[0]};
  assign edge_valid    = {r_ok[1], l_ok[1], r_ok[0], l_ok[0]};

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (tap_req && !tap_ack) |=> (tap_req && $stable(tap_dir_up)));
  p_cstart_after_lim_r7: assert property (@(posedge clk) disable iff (!arst_n)
    limits_done |=> center_start);
  p_flags_onehot_r7: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({limits_done, center_start, center_done}));
  p_lim_order_r6: assert property (@(posedge clk) disable iff (!arst_n)
    limits_done |-> (lim_lo <= lim_hi));
  p_byte_range_r9: assert property (@(posedge clk) disable iff (!arst_n)
    int'(byte_idx) < NUM_BYTES);
  p_done_hold_r11: assert property (@(posedge clk) disable iff (!arst_n)
    (cal_done && !cal_start) |=> cal_done);
  p_nf_sticky_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (win_not_found && !cal_start) |=> win_not_found);
endmodule

// File: tb/dwin_tap_cal_test.sv
`timescale 1ns/1ps
module dwin_tap_cal_test;
  localparam int NB = 2, TW = 6, ST = 4, TOPT = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            cal_start = 1'b0, tap_ack = 1'b0, smp_valid = 1'b1;
  logic            smp_rise_ok, smp_fall_ok;
  logic            cal_done, tap_req, tap_dir_up;
  logic            limits_done, center_start, center_done, win_not_found;
  logic [0:0]      byte_idx;
  logic [4*TW-1:0] edge_taps;
  logic [3:0]      edge_valid;
  logic [TW-1:0]   lim_lo, lim_hi;
  logic [NB*TW-1:0] final_taps;

  dwin_tap_cal #(.NUM_BYTES(NB), .TAP_W(TW), .SETTLE(ST)) uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_done(cal_done),
    .byte_idx(byte_idx), .tap_req(tap_req), .tap_dir_up(tap_dir_up),
    .tap_ack(tap_ack), .smp_valid(smp_valid), .smp_rise_ok(smp_rise_ok),
    .smp_fall_ok(smp_fall_ok), .edge_taps(edge_taps), .edge_valid(edge_valid),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .limits_done(limits_done),
    .center_start(center_start), .center_done(center_done),
    .win_not_found(win_not_found), .final_taps(final_taps)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  int ra [NB], rb [NB], fa [NB], fb [NB];
  bit rn [NB], fn [NB];
  int btap [NB], inc_cnt [NB], dec_cnt [NB], cd_cnt [NB], ld_cnt [NB];
  int set_cnt = 100;
  logic [4*TW-1:0] cap_e [NB];
  logic [3:0]      cap_v [NB];
  int cap_lo [NB], cap_hi [NB];
  bit prev_ld = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit in_win(int t, int a, int b, bit n);
    return !n && (t >= a) && (t <= b);
  endfunction

  // lane model: results are inverted until ST cycles after a tap change (R12)
  always_comb begin
    logic gr, gf;
    int bi;
    bi = int'(byte_idx);
    gr = in_win(btap[bi], ra[bi], rb[bi], rn[bi]);
    gf = in_win(btap[bi], fa[bi], fb[bi], fn[bi]);
    smp_rise_ok = (set_cnt >= ST) ? gr : !gr;
    smp_fall_ok = (set_cnt >= ST) ? gf : !gf;
  end

  // delay control model
  always @(negedge clk) begin
    int bi;
    bi = int'(byte_idx);
    if (tap_req && !tap_ack) begin
      tap_ack <= 1'b1;
      set_cnt <= 0;
      if (tap_dir_up) begin
        btap[bi] <= btap[bi] + 1; inc_cnt[bi] <= inc_cnt[bi] + 1;
      end else begin
        btap[bi] <= btap[bi] - 1; dec_cnt[bi] <= dec_cnt[bi] + 1;
      end
    end else begin
      tap_ack <= 1'b0;
      if (set_cnt < 1000) set_cnt <= set_cnt + 1;
    end
  end

  // monitor and watchdog
  always @(negedge clk) begin
    int bi;
    cyc++;
    bi = int'(byte_idx);
    if (prev_ld) chk(center_start === 1'b1, "R7 center_start one cycle after limits_done",
                     int'(center_start), 1);
    prev_ld = limits_done;
    if (limits_done) begin
      cap_e[bi] = edge_taps; cap_v[bi] = edge_valid;
      cap_lo[bi] = int'(lim_lo); cap_hi[bi] = int'(lim_hi);
      ld_cnt[bi]++;
    end
    if (center_done) cd_cnt[bi]++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic set_lane(int b, int a1, int b1, bit n1, int a2, int b2, bit n2);
    ra[b] = a1; rb[b] = b1; rn[b] = n1; fa[b] = a2; fb[b] = b2; fn[b] = n2;
  endtask

  task automatic run_cal();
    for (int b = 0; b < NB; b++) begin
      btap[b] = 0; inc_cnt[b] = 0; dec_cnt[b] = 0; cd_cnt[b] = 0; ld_cnt[b] = 0;
      cap_v[b] = 4'hx;
    end
    @(negedge clk); cal_start = 1'b1;
    @(negedge clk); cal_start = 1'b0;
    chk(cal_done == 1'b0, "R11 start clears cal_done", int'(cal_done), 0);
    for (int w = 0; w < 20000 && !cal_done; w++) @(negedge clk);
    chk(cal_done == 1'b1, "R11 cal_done after last byte", int'(cal_done), 1);
  endtask

  // expected results derived from the requirement rules
  task automatic check_byte(int b);
    bit rlv, rrv, flv, frv, rh, fh, none;
    int rlo, rhi, flo, fhi, olo, ohi, lo, hi, tgt;
    logic [3:0] ev;
    rlv = !rn[b] && ra[b] > 0;    rrv = !rn[b] && rb[b] < TOPT;   // R3 R4
    flv = !fn[b] && fa[b] > 0;    frv = !fn[b] && fb[b] < TOPT;
    ev = {frv, flv, rrv, rlv};
    chk(cap_v[b] === ev, $sformatf("R5 R12 byte %0d edge_valid", b), int'(cap_v[b]), int'(ev));
    if (rlv) chk(int'(cap_e[b][5:0]) == ra[b], $sformatf("R3 byte %0d rise left", b), int'(cap_e[b][5:0]), ra[b]);
    if (rrv) chk(int'(cap_e[b][11:6]) == rb[b], $sformatf("R4 byte %0d rise right", b), int'(cap_e[b][11:6]), rb[b]);
    if (flv) chk(int'(cap_e[b][17:12]) == fa[b], $sformatf("R3 byte %0d fall left", b), int'(cap_e[b][17:12]), fa[b]);
    if (frv) chk(int'(cap_e[b][23:18]) == fb[b], $sformatf("R4 byte %0d fall right", b), int'(cap_e[b][23:18]), fb[b]);
    rlo = rlv ? ra[b] : 0; rhi = rrv ? rb[b] : TOPT;
    flo = flv ? fa[b] : 0; fhi = frv ? fb[b] : TOPT;
    rh = rlv | rrv; fh = flv | frv; none = 1'b0;
    olo = (rlo > flo) ? rlo : flo; ohi = (rhi < fhi) ? rhi : fhi;
    if (rh && fh && olo <= ohi) begin lo = olo; hi = ohi; end
    else if (rh) begin lo = rlo; hi = rhi; end
    else if (fh) begin lo = flo; hi = fhi; end
    else begin lo = 0; hi = TOPT; none = 1'b1; end
    tgt = none ? 0 : (lo + hi) / 2;
    chk(cap_lo[b] == lo, $sformatf("R6 byte %0d lim_lo", b), cap_lo[b], lo);
    chk(cap_hi[b] == hi, $sformatf("R6 byte %0d lim_hi", b), cap_hi[b], hi);
    chk(int'(final_taps[b*TW +: TW]) == tgt, $sformatf("R8 R10 byte %0d final tap", b),
        int'(final_taps[b*TW +: TW]), tgt);
    chk(inc_cnt[b] == TOPT, $sformatf("R2 byte %0d increment steps", b), inc_cnt[b], TOPT);
    chk(dec_cnt[b] == TOPT - tgt, $sformatf("R8 byte %0d decrement steps", b), dec_cnt[b], TOPT - tgt);
    chk(cd_cnt[b] == 1, $sformatf("R8 byte %0d center_done pulses", b), cd_cnt[b], 1);
    chk(ld_cnt[b] == 1, $sformatf("R9 byte %0d limits_done once", b), ld_cnt[b], 1);
  endtask

  task automatic t_reset();
    chk(cal_done == 0 && tap_req == 0 && limits_done == 0 && center_start == 0 &&
        center_done == 0 && win_not_found == 0, "R1 flags low after reset", 1, 0);
    chk(byte_idx == 0, "R1 byte_idx zero", int'(byte_idx), 0);
    chk(final_taps == '0, "R1 final_taps zero", int'(final_taps), 0);
  endtask

  task automatic t_overlap();
    set_lane(0, 10, 40, 0, 20, 50, 0);
    set_lane(1, 5, 25, 0, 8, 30, 0);
    run_cal();
    for (int b = 0; b < NB; b++) check_byte(b);
    chk(win_not_found == 0, "R10 no flag with windows", int'(win_not_found), 0);
  endtask

  task automatic t_one_side();
    set_lane(0, 0, 30, 0, 0, 0, 1);
    set_lane(1, 50, 63, 0, 0, 0, 1);
    run_cal();
    for (int b = 0; b < NB; b++) check_byte(b);
  endtask

  task automatic t_no_window();
    set_lane(0, 0, 0, 1, 0, 0, 1);
    set_lane(1, 10, 20, 0, 10, 20, 0);
    run_cal();
    for (int b = 0; b < NB; b++) check_byte(b);
    chk(win_not_found == 1, "R10 flag set and held", int'(win_not_found), 1);
  endtask

  task automatic t_disjoint();
    set_lane(0, 5, 15, 0, 30, 40, 0);
    set_lane(1, 0, 63, 0, 12, 50, 0);
    run_cal();
    for (int b = 0; b < NB; b++) check_byte(b);
    chk(win_not_found == 0, "R10 start clears flag", int'(win_not_found), 0);
    repeat (20) @(negedge clk);
    chk(cal_done == 1 && tap_req == 0, "R11 done held while idle", int'(cal_done), 1);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      btap[b] = 0; inc_cnt[b] = 0; dec_cnt[b] = 0;
      set_lane(b, 0, 0, 1, 0, 0, 1);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_overlap();
    t_one_side();
    t_no_window();
    t_disjoint();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule